// File: doc/BRIEF.md
# Parity-Protected FFT Bank Corrector

This block guards a bank of four FFT cores that run in parallel. On the input side it forms the operand for a fifth, redundant FFT core. That operand is the component-wise sum of the four time-domain samples going into the data cores. On the output side it takes, bin by bin, the four data spectra and the redundant spectrum. It also takes four error flags, one per data core, which come from external energy (Parseval) checks. When exactly one flag is raised for a frame, it replaces that core's bins with the redundant bins minus the other three cores' bins. That value is the lost spectrum, because the transform is linear.

The flags are captured on the first bin of each frame and held for the rest of that frame. The detection decision is kept in three copies and resolved by bitwise majority. Each output beat carries a status word:
- a one-hot lane field,
- a corrected bit,
- an uncorrectable bit.

When two or more flags are raised, the data passes through unchanged and only the uncorrectable bit is set. The FFT cores and the energy checks are outside this block.

Top module: `fft_parity_guard`

## Requirements
- R1: `par_src_re`/`par_src_im` equal, combinationally, the signed sum of the four lane samples in `src_re`/`src_im`. Lane l sits in bits [l*IW +: IW]. The result is IW+2 bits wide and never overflows, even at full-scale inputs of either sign.
- R2: `fix_vld` is `bin_vld` delayed by exactly one clock cycle. Output data and status change only on cycles that follow a `bin_vld` beat.
- R3: With no flag in force, each output lane equals the matching input lane one cycle earlier, and `fix_stat` is 0.
- R4: With exactly one flag k in force, output lane k equals the low OW bits of (redundant bin − sum of the other three lanes), per component, and the other lanes pass unchanged. `fix_stat` is then {1'b0, 1'b1, one-hot k}, with bit 5 = uncorrectable, bit 4 = corrected, and bits 3:0 = lane.
- R5: The flags in force are `chk_flag` on a beat with `bin_first` high. On later beats they are the values captured at the last such beat, and `chk_flag` is ignored there.
- R6: With two or more flags in force, all lanes pass unchanged and `fix_stat` is 6'b100000.
- R7: With no flag in force, the redundant bins have no effect on any output, including when they are corrupted.
- R8: A flag raised on a lane whose data is in fact correct gives output equal to that correct data.
- R9: During and after reset, `fix_vld` is 0, `fix_stat` is 0, and the captured flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_re | input | 4*IW | Real parts of the four lane time samples |
| src_im | input | 4*IW | Imaginary parts of the four lane time samples |
| par_src_re | output | IW+2 | Real operand for the redundant FFT |
| par_src_im | output | IW+2 | Imaginary operand for the redundant FFT |
| bin_vld | input | 1 | A bin beat is present on the spectrum inputs |
| bin_first | input | 1 | This beat is the first bin of a frame |
| chk_flag | input | 4 | Energy-check failure per lane, read on first bins |
| bin_re | input | 4*OW | Real parts of the four data spectra |
| bin_im | input | 4*OW | Imaginary parts of the four data spectra |
| par_bin_re | input | OW+2 | Real part of the redundant spectrum |
| par_bin_im | input | OW+2 | Imaginary part of the redundant spectrum |
| fix_vld | output | 1 | Corrected beat present |
| fix_re | output | 4*OW | Real parts of the corrected spectra |
| fix_im | output | 4*OW | Imaginary parts of the corrected spectra |
| fix_stat | output | 6 | {uncorrectable, corrected, lane one-hot} |

## Verification
Frames with no flags are given deliberately corrupted redundant bins. This separates true pass-through from a corrector that always rebuilds. Single-flag frames with a corrupted lane show that the rebuild reaches the right lane and leaves the others alone. A false-alarm frame, with the data intact, shows that the rebuild reproduces clean data. Flags that change in the middle of a frame separate per-frame capture from per-beat sampling. A two-flag frame checks that the block falls back to pass-through. Full-scale positive and negative samples test the widened input adder.

// File: rtl/fft_parity_guard.sv
module fft_parity_guard #(
  parameter int IW = 12,
  parameter int OW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*IW-1:0]   src_re,
  input  logic [4*IW-1:0]   src_im,
  output logic [IW+1:0]     par_src_re,
  output logic [IW+1:0]     par_src_im,
  input  logic              bin_vld,
  input  logic              bin_first,
  input  logic [3:0]        chk_flag,
  input  logic [4*OW-1:0]   bin_re,
  input  logic [4*OW-1:0]   bin_im,
  input  logic [OW+1:0]     par_bin_re,
  input  logic [OW+1:0]     par_bin_im,
  output logic              fix_vld,
  output logic [4*OW-1:0]   fix_re,
  output logic [4*OW-1:0]   fix_im,
  output logic [5:0]        fix_stat
);
  localparam int PW = IW + 2;
  localparam int CW = OW + 2;

  logic signed [PW-1:0] sum_src_re, sum_src_im;
  logic signed [CW-1:0] sum_bin_re, sum_bin_im;

  always_comb begin
    sum_src_re = '0;
    sum_src_im = '0;
    sum_bin_re = '0;
    sum_bin_im = '0;
    for (int l = 0; l < 4; l++) begin
      sum_src_re = sum_src_re + PW'(signed'(src_re[l*IW +: IW]));
      sum_src_im = sum_src_im + PW'(signed'(src_im[l*IW +: IW]));
      sum_bin_re = sum_bin_re + CW'(signed'(bin_re[l*OW +: OW]));
      sum_bin_im = sum_bin_im + CW'(signed'(bin_im[l*OW +: OW]));
    end
  end

  assign par_src_re = sum_src_re;
  assign par_src_im = sum_src_im;

  logic [11:0] rep_mask;

  for (genvar t = 0; t < 3; t++) begin : g_rep
    logic [3:0] held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      held <= '0;
      else if (bin_vld && bin_first)   held <= chk_flag;
    end
    assign rep_mask[t*4 +: 4] = bin_first ? chk_flag : held;
  end

  logic [3:0] vmask;
  logic [2:0] nflag;
  logic       one_err, multi_err;

  assign vmask = (rep_mask[3:0] & rep_mask[7:4]) |
                 (rep_mask[3:0] & rep_mask[11:8]) |
                 (rep_mask[7:4] & rep_mask[11:8]);
  assign nflag     = 3'($countones(vmask));
  assign one_err   = (nflag == 3'd1);
  assign multi_err = (nflag > 3'd1);

  logic [4*OW-1:0] nxt_re, nxt_im;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic signed [CW-1:0] rb_re, rb_im;
    assign rb_re = $signed(par_bin_re) - sum_bin_re + CW'(signed'(bin_re[l*OW +: OW]));
    assign rb_im = $signed(par_bin_im) - sum_bin_im + CW'(signed'(bin_im[l*OW +: OW]));
    assign nxt_re[l*OW +: OW] = (one_err && vmask[l]) ? rb_re[OW-1:0] : bin_re[l*OW +: OW];
    assign nxt_im[l*OW +: OW] = (one_err && vmask[l]) ? rb_im[OW-1:0] : bin_im[l*OW +: OW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_vld  <= 1'b0;
      fix_re   <= '0;
      fix_im   <= '0;
      fix_stat <= '0;
    end else begin
      fix_vld <= bin_vld;
      if (bin_vld) begin
        fix_re   <= nxt_re;
        fix_im   <= nxt_im;
        fix_stat <= {multi_err, one_err, one_err ? vmask : 4'b0000};
      end
    end
  end
endmodule

// File: rtl/fft_parity_guard_chk.sv
module fft_parity_guard_chk #(
  parameter int OW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bin_vld,
  input logic            bin_first,
  input logic [4*OW-1:0] bin_re,
  input logic            fix_vld,
  input logic [4*OW-1:0] fix_re,
  input logic [5:0]      fix_stat
);
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bin_vld |=> fix_vld);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !bin_vld |=> !fix_vld);
  a_r4_single_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    fix_stat[4] |-> ($countones(fix_stat[3:0]) == 1 && !fix_stat[5]));
  a_r6_multi_clean: assert property (@(posedge clk) disable iff (!rst_n)
    fix_stat[5] |-> (fix_stat[4:0] == 5'd0));
  a_r5_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_vld && !bin_first) |=> $stable(fix_stat));
  a_r3_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_vld && fix_stat == 6'd0) |-> (fix_re == $past(bin_re)));
endmodule

bind fft_parity_guard fft_parity_guard_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bin_vld(bin_vld), .bin_first(bin_first),
  .bin_re(bin_re), .fix_vld(fix_vld), .fix_re(fix_re), .fix_stat(fix_stat)
);

// File: tb/fft_parity_guard_tb.sv
module fft_parity_guard_tb;
  localparam int IW = 12;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4*IW-1:0] src_re = '0, src_im = '0;
  logic [IW+1:0] par_src_re, par_src_im;
  logic bin_vld = 1'b0, bin_first = 1'b0;
  logic [3:0] chk_flag = '0;
  logic [4*OW-1:0] bin_re = '0, bin_im = '0;
  logic [OW+1:0] par_bin_re = '0, par_bin_im = '0;
  logic fix_vld;
  logic [4*OW-1:0] fix_re, fix_im;
  logic [5:0] fix_stat;

  always #2 clk = ~clk;

  fft_parity_guard #(.IW(IW), .OW(OW)) u_dut (.*);

  int vectors = 0, fails = 0;
  int lre[4], lim[4], pre, pim;
  int held = 0;
  logic [OW-1:0] e_re[4], e_im[4];
  logic [5:0] e_stat = '0;

  task automatic cmp(string req, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic beat(string req, bit vld, bit first, int flags);
    int eff, cnt, k;
    for (int l = 0; l < 4; l++) begin
      bin_re[l*OW +: OW] = lre[l][OW-1:0];
      bin_im[l*OW +: OW] = lim[l][OW-1:0];
    end
    par_bin_re = pre[OW+1:0];
    par_bin_im = pim[OW+1:0];
    bin_vld = vld; bin_first = first; chk_flag = flags[3:0];
    eff = first ? flags : held;
    cnt = 0; k = 0;
    for (int l = 0; l < 4; l++) if (eff[l]) begin cnt++; k = l; end
    if (vld) begin
      for (int l = 0; l < 4; l++) begin
        e_re[l] = lre[l][OW-1:0];
        e_im[l] = lim[l][OW-1:0];
      end
      if (cnt == 1) begin
        int rr, ri;
        rr = pre; ri = pim;
        for (int l = 0; l < 4; l++) if (l != k) begin rr -= lre[l]; ri -= lim[l]; end
        e_re[k] = rr[OW-1:0];
        e_im[k] = ri[OW-1:0];
        e_stat = {2'b01, eff[3:0]};
      end else if (cnt > 1) e_stat = 6'b100000;
      else e_stat = 6'd0;
      if (first) held = flags;
    end
    @(negedge clk);
    vectors++;
    cmp("R2", "fix_vld", int'(fix_vld), int'(vld));
    cmp(req, "fix_stat", int'(fix_stat), int'(e_stat));
    for (int l = 0; l < 4; l++) begin
      cmp(req, "fix_re", int'(fix_re[l*OW +: OW]), int'(e_re[l]));
      cmp(req, "fix_im", int'(fix_im[l*OW +: OW]), int'(e_im[l]));
    end
  endtask

  task automatic make(int seed, int bad_lane, bit bad_par);
    pre = 0; pim = 0;
    for (int l = 0; l < 4; l++) begin
      lre[l] = ((seed * 37 + l * 1009) % 4001) - 2000;
      lim[l] = ((seed * 53 + l * 611) % 3001) - 1500;
      pre += lre[l]; pim += lim[l];
    end
    if (bad_lane >= 0) begin
      lre[bad_lane] = lre[bad_lane] ^ 32'h0100;
      lim[bad_lane] = lim[bad_lane] + 77;
    end
    if (bad_par) begin pre += 12345; pim -= 999; end
  endtask

  task automatic srccheck(int a, int b);
    int s;
    for (int l = 0; l < 4; l++) begin
      src_re[l*IW +: IW] = (l < 2) ? a[IW-1:0] : b[IW-1:0];
      src_im[l*IW +: IW] = b[IW-1:0];
    end
    #1;
    vectors++;
    s = 2 * a + 2 * b;
    cmp("R1", "par_src_re", int'($signed(par_src_re)), s);
    cmp("R1", "par_src_im", int'($signed(par_src_im)), 4 * b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < 4; l++) begin e_re[l] = '0; e_im[l] = '0; end
    repeat (3) @(negedge clk);
    vectors++;
    cmp("R9", "fix_vld reset", int'(fix_vld), 0);
    cmp("R9", "fix_stat reset", int'(fix_stat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    srccheck(2047, 2047);
    srccheck(-2048, -2048);
    srccheck(-2048, 2047);
    srccheck(123, -77);
    make(1, -1, 0);
    beat("R9", 1, 0, 0);
    for (int b = 0; b < 4; b++) begin make(10 + b, -1, 1); beat("R7", 1, b == 0, 0); end
    for (int b = 0; b < 4; b++) begin make(20 + b, 2, 0); beat("R4", 1, b == 0, 4'b0100); end
    for (int b = 0; b < 4; b++) begin make(30 + b, 1, 0); beat("R5", 1, b == 0, (b == 0) ? 4'b0010 : 4'b1001); end
    beat("R2", 0, 0, 0);
    for (int b = 0; b < 4; b++) begin make(40 + b, 3, 0); beat("R6", 1, b == 0, 4'b1010); end
    for (int b = 0; b < 4; b++) begin make(50 + b, -1, 0); beat("R8", 1, b == 0, 4'b0001); end
    for (int b = 0; b < 3; b++) begin make(60 + b, -1, 0); beat("R3", 1, b == 0, 0); end
    beat("R2", 0, 0, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule